// File: doc/BRIEF.md
# Burst Read Master with Beat Credit Tracking

This block reads a contiguous run of words from a memory controller port and delivers them, in address order, on a valid/ready stream. A command gives a base word address and a length in words. The block cuts that length into burst requests of at most `MAX_BURST` beats. Each request goes out as one address with a burst count, and the controller answers with that many data beats.

The controller may refuse a request by holding `mem_ready` low, for as long as it needs. The master raises `mem_read` without looking at `mem_ready`. While a request is refused, the request stays frozen. Returning beats land in an internal FIFO. The master keeps a count of beats it has requested but not yet received. It asks for a new burst only when the FIFO space not yet claimed covers that burst, so the stream consumer can stall for any length of time without losing data.

Top module: `burst_read_master`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `mem_read`, `out_valid`, `busy` and `done` are all 0.
- R2: Once a transfer is started, `mem_read` is raised even while `mem_ready` is low.
- R3: While `mem_read` is 1 and `mem_ready` is 0, on the next cycle `mem_read` is still 1 and `mem_addr` and `mem_burst` are unchanged.
- R4: Each burst carries the smaller of `MAX_BURST` and the words still to be requested. The first burst starts at the base address, and each following address is the previous one plus the previous burst count, in word units.
- R5: Beats held in the FIFO plus beats requested but not yet returned never exceed `FIFO_DEPTH`. With the stream stalled, the master asks for exactly as many beats as fit.
- R6: The stream delivers every returned word once, in request order. The count of outstanding beats also stays correct when a request is accepted in the same cycle that a beat returns.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R8: `done` pulses for exactly one cycle once every beat of the transfer has entered the FIFO and no beat is outstanding. `busy` falls in that same cycle.
- R9: A `cmd_start` while `busy` is 1 is ignored: it issues no requests and produces no extra `done`.
- R10: A start with `cmd_len` equal to 0 issues no request and gives a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Starts a transfer when idle |
| cmd_base | input | ADDR_W | First word address |
| cmd_len | input | LEN_W | Number of words to read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Burst start address |
| mem_burst | output | $clog2(MAX_BURST+1) | Burst length in beats |
| mem_read | output | 1 | Read request |
| mem_ready | input | 1 | Controller accepts the request this cycle |
| mem_rdata | input | DATA_W | Returning read word |
| mem_rvalid | input | 1 | `mem_rdata` carries a beat |
| out_data | output | DATA_W | Stream word |
| out_valid | output | 1 | Stream word present |
| out_ready | input | 1 | Consumer takes the word |

## Verification
The bench uses the default parameters: `MAX_BURST` of 8, `FIFO_DEPTH` of 16, and 32-bit addresses and data. A 19-word transfer therefore ends in a 3-beat tail burst. With the stream stalled, the FIFO limit is reached after exactly two full bursts. The memory model answers one cycle after acceptance, which puts accepted requests and returning beats in the same cycle whenever `mem_ready` toggles. That same-cycle case is what the credit counter has to get right.

// File: rtl/burst_read_master.sv
module burst_read_master #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_start,
  input  logic [ADDR_W-1:0]              cmd_base,
  input  logic [LEN_W-1:0]               cmd_len,
  output logic                           busy,
  output logic                           done,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [$clog2(MAX_BURST+1)-1:0] mem_burst,
  output logic                           mem_read,
  input  logic                           mem_ready,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic                           mem_rvalid,
  output logic [DATA_W-1:0]              out_data,
  output logic                           out_valid,
  input  logic                           out_ready
);
  localparam int BC_W  = $clog2(MAX_BURST+1);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic              active;
  logic [LEN_W-1:0]  req_left, push_left;
  logic [ADDR_W-1:0] next_addr;
  logic [CNT_W-1:0]  pending, fifo_cnt;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] fifo_mem [FIFO_DEPTH];
  logic [BC_W-1:0]   nxt_burst;
  logic [CNT_W:0]    reserved, room;
  logic              accept, can_issue, finish, pop;

  assign busy      = active;
  assign accept    = mem_read && mem_ready;
  assign pop       = out_valid && out_ready;
  assign out_valid = fifo_cnt != '0;
  assign out_data  = fifo_mem[rd_ptr];
  assign nxt_burst = (req_left < LEN_W'(MAX_BURST)) ? req_left[BC_W-1:0] : BC_W'(MAX_BURST);

  always_comb begin
    reserved = {1'b0, fifo_cnt} + {1'b0, pending};
    if (mem_read) reserved = reserved + (CNT_W+1)'(mem_burst);
    room = (CNT_W+1)'(FIFO_DEPTH) - reserved;
  end

  assign can_issue = active && (req_left != '0) && (!mem_read || mem_ready)
                     && (room >= (CNT_W+1)'(nxt_burst));
  assign finish    = active && (req_left == '0) && (push_left == '0)
                     && !mem_read && (pending == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      done      <= 1'b0;
      mem_read  <= 1'b0;
      mem_addr  <= '0;
      mem_burst <= '0;
      next_addr <= '0;
      req_left  <= '0;
      push_left <= '0;
    end else begin
      done <= finish;
      if (!active && cmd_start) begin
        active    <= 1'b1;
        next_addr <= cmd_base;
        req_left  <= cmd_len;
        push_left <= cmd_len;
      end else if (finish) begin
        active <= 1'b0;
      end
      if (can_issue) begin
        mem_read  <= 1'b1;
        mem_addr  <= next_addr;
        mem_burst <= nxt_burst;
        next_addr <= next_addr + ADDR_W'(nxt_burst);
        req_left  <= req_left - LEN_W'(nxt_burst);
      end else if (accept) begin
        mem_read <= 1'b0;
      end
      if (active && mem_rvalid && push_left != '0) push_left <= push_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      case ({accept, mem_rvalid})
        2'b10:   pending <= pending + CNT_W'(mem_burst);
        2'b11:   pending <= pending + CNT_W'(mem_burst) - 1'b1;
        2'b01:   if (pending != '0) pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_cnt <= '0;
    end else begin
      if (mem_rvalid) wr_ptr <= wr_ptr + 1'b1;
      if (pop)        rd_ptr <= rd_ptr + 1'b1;
      case ({mem_rvalid, pop})
        2'b10:   fifo_cnt <= fifo_cnt + 1'b1;
        2'b01:   fifo_cnt <= fifo_cnt - 1'b1;
        default: fifo_cnt <= fifo_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rvalid) fifo_mem[wr_ptr] <= mem_rdata;
  end
endmodule

// File: rtl/burst_read_master_chk.sv
module burst_read_master_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAX_BURST  = 8,
  parameter int FIFO_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           mem_read,
  input logic                           mem_ready,
  input logic [ADDR_W-1:0]              mem_addr,
  input logic [$clog2(MAX_BURST+1)-1:0] mem_burst,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] pending,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [DATA_W-1:0]              out_data,
  input logic                           done
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read && !mem_ready |=> mem_read && $stable(mem_addr) && $stable(mem_burst));

  assert_burst_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |-> (mem_burst != '0) && (32'(mem_burst) <= MAX_BURST));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_cnt) + 32'(pending)) <= FIFO_DEPTH);

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pending == '0) && !mem_read);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind burst_read_master burst_read_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_read(mem_read), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_burst(mem_burst), .fifo_cnt(fifo_cnt), .pending(pending),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/burst_read_master_bench.sv
module burst_read_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_len = '0;
  logic        busy, done, mem_read;
  logic [31:0] mem_addr;
  logic [3:0]  mem_burst;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int ready_mode = 1, rv_mode = 1, or_mode = 1;
  int nreq = 0, ngot = 0, acc_beats = 0;
  logic [31:0] req_addr [32];
  int          req_len  [32];
  logic [31:0] got      [128];
  logic [31:0] q [$];

  burst_read_master #(.ADDR_W(32), .DATA_W(32), .LEN_W(16), .MAX_BURST(8), .FIFO_DEPTH(16))
  u_burst_read_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_read(mem_read),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready));

  always #10 clk = ~clk;

  function automatic logic [31:0] dat(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic pat(input int mode, input int c);
    if (mode == 0) return 1'b0;
    if (mode == 1) return 1'b1;
    return ((c & 1) ^ ((c >> 2) & 1)) != 0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rvalid && q.size() > 0) q.delete(0);
      if (mem_read && mem_ready) begin
        if (nreq < 32) begin
          req_addr[nreq] = mem_addr;
          req_len[nreq]  = int'(mem_burst);
        end
        nreq++;
        acc_beats += int'(mem_burst);
        for (int i = 0; i < int'(mem_burst); i++) q.push_back(mem_addr + 32'(i));
      end
      if (out_valid && out_ready) begin
        if (ngot < 128) got[ngot] = out_data;
        ngot++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_ready  = pat(ready_mode, cyc);
    out_ready  = pat(or_mode, cyc + 1);
    mem_rvalid = rst_n && (q.size() > 0) && pat(rv_mode, cyc + 3);
    mem_rdata  = (q.size() > 0) ? dat(q[0]) : 32'h0;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_log();
    nreq = 0; ngot = 0; acc_beats = 0;
  endtask

  task automatic start(input logic [31:0] base, input logic [15:0] len);
    @(negedge clk);
    cmd_base = base; cmd_len = len; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done, {tag, " done seen"}, 32'(done), 1);
    check(!busy, "R8 busy low with done", 32'(busy), 0);
    @(negedge clk);
    check(!done, "R8 done one cycle", 32'(done), 0);
  endtask

  task automatic check_data(input logic [31:0] base, input int len, input string tag);
    repeat (40) @(negedge clk);
    check(ngot == len, {tag, " word count"}, 32'(ngot), 32'(len));
    for (int i = 0; i < len && i < 128; i++)
      check(got[i] == dat(base + 32'(i)), {tag, " word"}, got[i], dat(base + 32'(i)));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!mem_read && !out_valid && !busy && !done, "R1 reset outputs",
          {28'b0, mem_read, out_valid, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_stall_split();
    clear_log();
    ready_mode = 0; rv_mode = 1; or_mode = 1;
    start(32'd100, 16'd19);
    repeat (3) @(negedge clk);
    check(mem_read, "R2 read without ready", 32'(mem_read), 1);
    check(mem_addr == 32'd100 && mem_burst == 4'd8, "R3 stalled request", mem_addr, 100);
    repeat (8) @(negedge clk);
    check(mem_read && mem_addr == 32'd100 && mem_burst == 4'd8, "R3 still held", mem_addr, 100);
    check(nreq == 0, "R3 nothing accepted", 32'(nreq), 0);
    ready_mode = 1;
    wait_done("R8 split");
    check(nreq == 3, "R4 burst count", 32'(nreq), 3);
    check(req_addr[0] == 32'd100 && req_len[0] == 8, "R4 burst 0", req_addr[0], 100);
    check(req_addr[1] == 32'd108 && req_len[1] == 8, "R4 burst 1", req_addr[1], 108);
    check(req_addr[2] == 32'd116 && req_len[2] == 3, "R4 tail burst", 32'(req_len[2]), 3);
    check_data(32'd100, 19, "R6 split");
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    clear_log();
    ready_mode = 1; rv_mode = 1; or_mode = 0;
    start(32'h2000, 16'd40);
    repeat (60) @(negedge clk);
    check(acc_beats == 16, "R5 beats requested while stalled", 32'(acc_beats), 16);
    check(ngot == 0, "R7 nothing taken", 32'(ngot), 0);
    held = out_data;
    check(out_valid && held == dat(32'h2000), "R7 head word", held, dat(32'h2000));
    repeat (5) @(negedge clk);
    check(out_valid && out_data == held, "R7 word held", out_data, held);
    or_mode = 1;
    wait_done("R8 backpressure");
    check_data(32'h2000, 40, "R6 backpressure");
  endtask

  task automatic t_toggle();
    clear_log();
    ready_mode = 2; rv_mode = 1; or_mode = 2;
    start(32'd5, 16'd33);
    wait_done("R6 toggle");
    check(acc_beats == 33, "R6 beats requested", 32'(acc_beats), 33);
    check(nreq == 5, "R4 toggle bursts", 32'(nreq), 5);
    check_data(32'd5, 33, "R6 toggle");
  endtask

  task automatic t_busy_ignore();
    clear_log();
    ready_mode = 1; rv_mode = 2; or_mode = 1;
    start(32'h300, 16'd10);
    @(negedge clk);
    start(32'h900, 16'd5);
    wait_done("R9 first");
    repeat (30) @(negedge clk);
    check(!done && !busy, "R9 no second transfer", 32'(busy), 0);
    check(nreq == 2, "R9 request count", 32'(nreq), 2);
    check(req_addr[0] == 32'h300 && req_addr[1] == 32'h308, "R9 addresses", req_addr[1], 32'h308);
    check(ngot == 10, "R9 words", 32'(ngot), 10);
  endtask

  task automatic t_zero();
    clear_log();
    ready_mode = 1; rv_mode = 1; or_mode = 1;
    start(32'h40, 16'd0);
    wait_done("R10 zero length");
    check(nreq == 0, "R10 no requests", 32'(nreq), 0);
  endtask

  initial begin
    t_reset();
    t_stall_split();
    t_backpressure();
    t_toggle();
    t_busy_ignore();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule